// File: doc/BRIEF.md
# Shared-Ramp Multichannel ADC Capture Backend

This block is the digital half of a ramp-compare (single-slope) converter shared by many channels. A start request begins a conversion. For the length of the ramp, one common counter steps once per clock through its full range and is held in Gray code. Each channel has a comparator, outside this block, whose output rises when the shared ramp passes that channel's held voltage. On that rising edge the channel stores the current Gray count. A channel stores only its first edge of the conversion.

When the counter reaches full scale the conversion closes. Every stored Gray value is turned into plain binary and copied into that channel's result register. A channel that saw no edge reports the full-scale code and raises its no-crossing flag. A one-cycle done pulse then marks the results as valid. The results stay unchanged until the next conversion finishes. The comparator outputs are taken to be synchronous to the counting clock.

The controller steps through four named states:

- IDLE waits for start. A start seen in IDLE clears the counter and the capture flags, and the next state is RAMP.
- RAMP counts and lets channels capture. When the count is at full scale, the next state is FINISH.
- FINISH loads the binary results and flags, and the next state is DONE.
- DONE drives the done pulse, and the next state is IDLE.

Top module: `wramp_adc_backend`

## Requirements
- R1: After reset, busy_o and done_o are 0, every result field in code_o is 0 and every bit of nocross_o is 0.
- R2: A start_i sampled high in IDLE makes busy_o high from the next cycle. busy_o stays high for exactly CNT_MAX+2 cycles (4097 by default), which covers RAMP plus FINISH. While in IDLE with start_i low, busy_o stays low.
- R3: The ramp cycles are numbered from 0, the first clock edge in RAMP. Cycle k samples comparator levels that were driven after ramp cycle k-1 (or after the start edge, for k=0). A channel whose first rising comparator edge is sampled in ramp cycle k reports binary code k.
- R4: After its first capture, a channel ignores further comparator edges in the same conversion. Comparator edges outside RAMP have no effect.
- R5: A rising edge is a sample of 1 that follows a sample of 0. A comparator that is already high at the start edge and stays high produces no capture. If it falls and then rises, it captures at the rise.
- R6: A channel with no capture reports code 4095 (all ones) with its nocross_o bit set. A channel that captures in the last ramp cycle also reports 4095, but with its nocross_o bit clear.
- R7: done_o is a single-cycle pulse that rises two cycles after the ramp cycle holding full scale. code_o and nocross_o change only on the edge that raises done_o, and they hold until the next done.
- R8: A start_i pulse while busy_o is high is ignored. The conversion and its results are unaffected.
- R9: The shared count is held in Gray code. Successive counter values differ in at most one bit.
- R10: Channel i's result sits in code_o[i*12 +: 12] as plain binary. Its flag is nocross_o[i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled in IDLE |
| cmp_i | input | NCH (36) | Comparator outputs, one per channel |
| busy_o | output | 1 | High while the ramp runs and results are loaded |
| done_o | output | 1 | One-cycle pulse: new results valid |
| code_o | output | NCH*CW (432) | Binary results, 12 bits per channel |
| nocross_o | output | NCH (36) | Per-channel flag: no crossing during the ramp |

## Verification
The bench aims at the ends of the range. One channel crosses in ramp cycle 0 and one in the final cycle. A design that is off by one in its counter or its edge sampling shifts every code, or loses the final-cycle capture into the no-crossing case. The bench also drives a comparator that is high before the start edge, one that glitches after capturing, and a start pulse in the middle of a ramp. A design that treats levels as edges, recaptures, or restarts the ramp would report wrong codes for these. Edges in idle and a full sweep of distinct crossing points catch results that drift while idle and faulty Gray-to-binary conversion.

// File: rtl/wadc_pkg.sv
package wadc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RAMP   = 2'd1,
        ST_FINISH = 2'd2,
        ST_DONE   = 2'd3
    } wadc_state_e;

endpackage

// File: rtl/wadc_gray_cnt.sv
module wadc_gray_cnt #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          step_i,
    output logic [CW-1:0] gray_o,
    output logic          full_o
);
    localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

    logic [CW-1:0] bin_q;
    logic [CW-1:0] bin_nx;

    assign bin_nx = bin_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else if (clr_i) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else if (step_i) begin
            bin_q  <= bin_nx;
            gray_o <= bin_nx ^ (bin_nx >> 1);
        end
    end

    assign full_o = (bin_q == CNT_TOP);
endmodule

// File: rtl/wadc_ctrl.sv
module wadc_ctrl
    import wadc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic full_i,
    output logic clr_o,
    output logic ramp_o,
    output logic load_o,
    output logic busy_o,
    output logic done_o
);
    wadc_state_e state_q, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_nx = ST_RAMP;
            ST_RAMP:   if (full_i)  state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        clr_o  = 1'b0;
        ramp_o = 1'b0;
        load_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   clr_o = start_i;
            ST_RAMP:   begin ramp_o = 1'b1; busy_o = 1'b1; end
            ST_FINISH: begin load_o = 1'b1; busy_o = 1'b1; end
            ST_DONE:   done_o = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/wadc_channel.sv
module wadc_channel #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          ramp_i,
    input  logic          load_i,
    input  logic          cmp_i,
    input  logic [CW-1:0] gray_i,
    output logic [CW-1:0] code_o,
    output logic          nocross_o
);
    logic          cmp_q;
    logic          hit_q;
    logic [CW-1:0] gray_lat_q;
    logic [CW-1:0] bin_w;

    always_comb begin
        bin_w[CW-1] = gray_lat_q[CW-1];
        for (int k = CW - 2; k >= 0; k--) begin
            bin_w[k] = bin_w[k+1] ^ gray_lat_q[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q      <= 1'b0;
            hit_q      <= 1'b0;
            gray_lat_q <= '0;
            code_o     <= '0;
            nocross_o  <= 1'b0;
        end else begin
            cmp_q <= cmp_i;
            if (clr_i) begin
                hit_q <= 1'b0;
            end else if (ramp_i && cmp_i && !cmp_q && !hit_q) begin
                hit_q      <= 1'b1;
                gray_lat_q <= gray_i;
            end
            if (load_i) begin
                code_o    <= hit_q ? bin_w : {CW{1'b1}};
                nocross_o <= !hit_q;
            end
        end
    end
endmodule

// File: rtl/wramp_adc_backend.sv
module wramp_adc_backend #(
    parameter int NCH = 36,
    parameter int CW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NCH-1:0]    cmp_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [NCH*CW-1:0] code_o,
    output logic [NCH-1:0]    nocross_o
);
    logic          clr_w;
    logic          ramp_w;
    logic          load_w;
    logic          full_w;
    logic [CW-1:0] gray_w;

    wadc_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .full_i  (full_w),
        .clr_o   (clr_w),
        .ramp_o  (ramp_w),
        .load_o  (load_w),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    wadc_gray_cnt #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_w),
        .step_i (ramp_w),
        .gray_o (gray_w),
        .full_o (full_w)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        wadc_channel #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (clr_w),
            .ramp_i    (ramp_w),
            .load_i    (load_w),
            .cmp_i     (cmp_i[i]),
            .gray_i    (gray_w),
            .code_o    (code_o[i*CW +: CW]),
            .nocross_o (nocross_o[i])
        );
    end
endmodule

// File: rtl/wadc_chk.sv
module wadc_chk #(
    parameter int NCH = 36,
    parameter int CW  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [NCH*CW-1:0] code_o,
    input logic [NCH-1:0]    nocross_o,
    input logic [CW-1:0]     gray_w
);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));

    a_r7_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(code_o) && $stable(nocross_o)) |-> done_o);

    a_r2_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);

    a_r8_busy_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

    a_r9_gray_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gray_w ^ $past(gray_w)) <= 1);

    for (genvar i = 0; i < NCH; i++) begin : g_ovf
        a_r6_nocross_full: assert property (@(posedge clk) disable iff (!rst_n)
            nocross_o[i] |-> (code_o[i*CW +: CW] == {CW{1'b1}}));
    end
endmodule

bind wramp_adc_backend wadc_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .code_o    (code_o),
    .nocross_o (nocross_o),
    .gray_w    (gray_w)
);

// File: tb/wramp_adc_backend_tb.sv
module wramp_adc_backend_tb_top;
    localparam int NCH   = 36;
    localparam int CW    = 12;
    localparam int TOP   = (1 << CW) - 1;
    localparam int NEVER = 999999;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [NCH-1:0]    cmp_i = '0;
    logic              busy_o;
    logic              done_o;
    logic [NCH*CW-1:0] code_o;
    logic [NCH-1:0]    nocross_o;

    always #5 clk = ~clk;

    wramp_adc_backend #(.NCH(NCH), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
        .busy_o(busy_o), .done_o(done_o), .code_o(code_o), .nocross_o(nocross_o)
    );

    typedef struct {
        int code [NCH];
        bit nc   [NCH];
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   ended = 0;
    int   conv_done = 0;

    int pre_l [NCH];
    int fall  [NCH];
    int rise  [NCH];
    int glit  [NCH];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    function automatic bit lvl(input int c, input int i);
        if (i < fall[c]) return pre_l[c] != 0;
        return (i >= rise[c]) && (i != glit[c]);
    endfunction

    function automatic int field(input int c);
        return int'(code_o[c*CW +: CW]);
    endfunction

    task automatic clear_profile();
        for (int c = 0; c < NCH; c++) begin
            pre_l[c] = 0; fall[c] = 0; rise[c] = NEVER; glit[c] = -1;
        end
    endtask

    // R3 R5 R6: expected result from the first 0->1 of the sampled levels
    task automatic push_expected();
        exp_t e;
        for (int c = 0; c < NCH; c++) begin
            e.code[c] = TOP;
            e.nc[c]   = 1;
            for (int i = 0; i <= TOP; i++) begin
                bit prev = (i == 0) ? (pre_l[c] != 0) : lvl(c, i - 1);
                if (lvl(c, i) && !prev) begin
                    e.code[c] = i; e.nc[c] = 0;
                    break;
                end
            end
        end
        exp_q.push_back(e);
    endtask

    task automatic run_conv(input int mid_start);
        push_expected();
        @(negedge clk);
        for (int c = 0; c < NCH; c++) cmp_i[c] = pre_l[c] != 0;
        start_i = 1'b1;
        for (int i = 0; i <= TOP; i++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) cmp_i[c] = lvl(c, i);
            start_i = (i == mid_start);       // R8: start during the ramp
        end
        @(negedge clk);
        cmp_i   = '0;
        start_i = 1'b0;
        wait (conv_done == exp_q.size() + conv_done - exp_q.size() && exp_q.size() == 0);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: measures busy length and scores results on done
    initial begin
        int busy_len = 0;
        forever begin
            @(negedge clk);
            if (busy_o) busy_len++;
            if (done_o) begin
                exp_t e;
                check(busy_len == TOP + 2, "R2", "busy length", busy_len, TOP + 2);
                busy_len = 0;
                if (exp_q.size() == 0) begin
                    check(0, "R7", "done without a conversion", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    for (int c = 0; c < NCH; c++) begin
                        check(field(c) == e.code[c], "R3", $sformatf("ch%0d code", c),
                              field(c), e.code[c]);
                        check(nocross_o[c] == e.nc[c], "R6", $sformatf("ch%0d nocross", c),
                              int'(nocross_o[c]), int'(e.nc[c]));
                    end
                end
                @(negedge clk);
                check(done_o == 1'b0, "R7", "done width", int'(done_o), 0);
                conv_done++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "R2", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [NCH*CW-1:0] snap;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy_o == 0, "R1", "busy after reset", int'(busy_o), 0);
        check(done_o == 0, "R1", "done after reset", int'(done_o), 0);
        check(code_o == '0, "R1", "codes after reset", int'(code_o != '0), 0);
        check(nocross_o == '0, "R1", "flags after reset", int'(nocross_o != '0), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy_o == 0, "R2", "idle without start", int'(busy_o), 0);

        // Sweep: R3 R10 distinct crossing points, R6 last cycle and never
        clear_profile();
        for (int c = 0; c < NCH; c++) rise[c] = c * 113;
        rise[5]  = NEVER;
        rise[35] = TOP;
        run_conv(-1);

        // R4: edges while idle must not disturb held results
        snap = code_o;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            cmp_i = (k % 2 == 0) ? '1 : '0;
        end
        cmp_i = '0;
        repeat (2) @(negedge clk);
        check(code_o == snap, "R4", "codes after idle edges", int'(code_o != snap), 0);
        check(busy_o == 0, "R4", "busy after idle edges", int'(busy_o), 0);

        // R4 glitch after capture, R5 high before start, R8 mid-ramp start
        clear_profile();
        for (int c = 0; c < NCH; c++) rise[c] = c * 37 + 3;
        rise[0] = 10;  glit[0] = 20;
        pre_l[1] = 1;  fall[1] = NEVER;
        pre_l[2] = 1;  fall[2] = 5;  rise[2] = 50;
        pre_l[3] = 1;  fall[3] = 0;  rise[3] = 0;
        run_conv(100);
        check(field(0) == 10, "R4", "glitch channel keeps first code", field(0), 10);
        check(nocross_o[1] == 1, "R5", "high-before-start flagged", int'(nocross_o[1]), 1);
        check(field(2) == 50, "R5", "recapture after fall", field(2), 50);

        // R6 mostly silent channels, R3 crossing in ramp cycle 0
        clear_profile();
        rise[7] = 0;
        rise[8] = TOP - 1;
        run_conv(-1);
        check(field(7) == 0, "R3", "cycle-0 capture", field(7), 0);
        check(nocross_o[0] == 1, "R6", "silent channel flag", int'(nocross_o[0]), 1);

        finish_run();
    end
endmodule